// File: doc/BRIEF.md
# Eight-Level Intensity PWM Generator

This block produces the brightness-enable waveform that gates the row drivers of a small multi-digit dot-matrix display. A period is split into a fixed number of scan slots; a slot advances each time the scan logic pulses a tick. A 3-bit intensity code selects how many of the leading slots of each period keep the enable high. The steps are roughly logarithmic: code 000 is the brightest and code 111 is the dimmest. An override input defeats internal dimming and holds the enable on. A second output runs at half the duty of the main enable and is used when a cursor is displayed.

The intensity code is captured only on the tick that closes a period, so a code written mid-period never cuts a slot short or stretches one. A build-time parameter selects a low-power variant. In that variant code 000 maps to the 27 % step instead of full brightness, and the other codes are unchanged. Reset loads code 000, so the block comes up at the default brightness of the variant.

Top module: `intensity_pwm`

## Requirements
- R1: While reset is asserted, and after it is released with no tick seen, the slot index is 0 and the captured code is 000. The standard variant then drives `bright_en`=1. The low-power variant drives `bright_en`=1 in slot 0. `half_en` is 0 in both variants.
- R2: With the default 30-slot period and `ext_off`=0, the standard variant holds `bright_en` high in slots 0 to N-1 of each period and low in the others. N is 30, 18, 12, 8, 5, 3, 2 and 1 for codes 000 to 111.
- R3: In the low-power variant (`LOW_PWR`=1), code 000 gives N=8. The other seven codes give the same N as in R2.
- R4: `lvl_code` is sampled only on the tick that moves the slot from the last slot to 0. For the whole of the current period the previously captured code stays in force.
- R5: While `ext_off`=1, `bright_en` is 1 in every slot whatever the captured code, from the same cycle onward.
- R6: `half_en` equals `bright_en` AND a phase bit. The phase bit is 0 after reset and toggles on every tick, so with an even period `half_en` can be high only in odd slots.
- R7: The slot index and the phase bit change only on a cycle with `slot_tick`=1. With no tick, both outputs hold their values.
- R8: After PERIOD ticks the slot index returns to 0 and a new period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slot_tick | input | 1 | One-cycle pulse that advances the scan slot |
| lvl_code | input | 3 | Intensity code, 000 brightest, 111 dimmest |
| ext_off | input | 1 | 1 = internal dimming disabled, enable held on |
| bright_en | output | 1 | Main brightness enable for the row drivers |
| half_en | output | 1 | Half-duty enable for cursor display |

## Verification
The bench steps through all eight codes on a standard and a low-power instance driven in parallel. It checks every slot of each period, so a wrong on-count, a gap inside the on-window, or a phase error on `half_en` each shows up at a distinct slot index. Each new code is presented for a full period before the period it should take effect in. Outputs that still follow the previous code there separate a correct period-boundary capture from an immediate one. A period with the override set at the dimmest code, a run of idle cycles between ticks, and a reset asserted mid-period cover the override, the hold and the default code.

// File: rtl/intensity_pwm_pkg.sv
package intensity_pwm_pkg;

  // Per-mille on-time for each intensity code; code 0 depends on the variant.
  function automatic int step_permille(input logic [2:0] code, input bit low_pwr);
    int pm;
    case (code)
      3'd0:    pm = low_pwr ? 270 : 1000;
      3'd1:    pm = 600;
      3'd2:    pm = 400;
      3'd3:    pm = 270;
      3'd4:    pm = 170;
      3'd5:    pm = 100;
      3'd6:    pm = 70;
      default: pm = 30;
    endcase
    return pm;
  endfunction

  // Number of leading on-slots in a period, rounded, never below one.
  function automatic int on_slots(input logic [2:0] code, input bit low_pwr, input int period);
    int n;
    n = (period * step_permille(code, low_pwr) + 500) / 1000;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/ipwm_rst_sync.sv
module ipwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/ipwm_slot_timer.sv
module ipwm_slot_timer #(
  parameter int PERIOD = 30,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] slot_q,
  output logic          phase_q,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] slot_d;
  logic          phase_d;

  assign wrap = tick && (slot_q == LAST);

  always_comb begin
    slot_d  = slot_q;
    phase_d = phase_q;
    if (tick) begin
      slot_d  = wrap ? '0 : slot_q + 1'b1;
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      slot_q  <= slot_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/ipwm_code_latch.sv
module ipwm_code_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] code_in,
  output logic [2:0] code_q
);
  logic [2:0] code_d;

  always_comb begin
    code_d = code_q;
    if (load) code_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= 3'd0;
    else if (load) code_q <= code_d;
  end
endmodule

// File: rtl/ipwm_duty_gate.sv
module ipwm_duty_gate
  import intensity_pwm_pkg::*;
#(
  parameter int PERIOD  = 30,
  parameter bit LOW_PWR = 1'b0,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic [2:0]    code_q,
  input  logic [CW-1:0] slot_q,
  input  logic          phase_q,
  input  logic          ext_off,
  output logic          bright_en,
  output logic          half_en
);
  int  on_n;
  logic in_window;

  always_comb begin
    on_n      = on_slots(code_q, LOW_PWR, PERIOD);
    in_window = (int'(slot_q) < on_n);
    bright_en = ext_off | in_window;
    half_en   = bright_en & phase_q;
  end
endmodule

// File: rtl/intensity_pwm.sv
module intensity_pwm #(
  parameter int PERIOD  = 30,
  parameter bit LOW_PWR = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_tick,
  input  logic [2:0] lvl_code,
  input  logic       ext_off,
  output logic       bright_en,
  output logic       half_en
);
  localparam int CW = $clog2(PERIOD);

  logic          rst_sync_n;
  logic [CW-1:0] slot_q;
  logic          phase_q;
  logic          wrap;
  logic [2:0]    code_q;

  ipwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipwm_slot_timer #(.PERIOD(PERIOD)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (slot_tick),
    .slot_q  (slot_q),
    .phase_q (phase_q),
    .wrap    (wrap)
  );

  ipwm_code_latch u_code (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (wrap),
    .code_in (lvl_code),
    .code_q  (code_q)
  );

  ipwm_duty_gate #(.PERIOD(PERIOD), .LOW_PWR(LOW_PWR)) u_gate (
    .code_q    (code_q),
    .slot_q    (slot_q),
    .phase_q   (phase_q),
    .ext_off   (ext_off),
    .bright_en (bright_en),
    .half_en   (half_en)
  );
endmodule

// File: rtl/intensity_pwm_chk.sv
module intensity_pwm_chk #(
  parameter int PERIOD = 30,
  localparam int CW = $clog2(PERIOD)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_tick,
  input logic          ext_off,
  input logic          bright_en,
  input logic          half_en,
  input logic [CW-1:0] slot_q,
  input logic          phase_q,
  input logic          wrap,
  input logic [2:0]    code_q
);
  // R6: cursor enable never on while the main enable is off
  assert_half_in_bright_R6: assert property (@(posedge clk) disable iff (!rst_n)
    half_en |-> bright_en);

  // R5: override holds the main enable on
  assert_override_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_off |-> bright_en);

  // R7: no tick, no slot or phase movement
  assert_hold_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> ($stable(slot_q) && $stable(phase_q)));

  // R4: captured code changes only after a period-closing tick
  assert_code_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(wrap));

  // R8: a closing tick starts a new period at slot 0
  assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (slot_q == '0));

  // R8: slot index stays inside the period
  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < PERIOD);
endmodule

bind intensity_pwm intensity_pwm_chk #(.PERIOD(PERIOD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_tick (slot_tick),
  .ext_off   (ext_off),
  .bright_en (bright_en),
  .half_en   (half_en),
  .slot_q    (slot_q),
  .phase_q   (phase_q),
  .wrap      (wrap),
  .code_q    (code_q)
);

// File: tb/sim_intensity_pwm.sv
module sim_intensity_pwm;
  localparam int CLK_NS = 10;
  localparam int PERIOD = 30;
  // expected on-slots per code, standard and low-power variant
  localparam int EXP_STD [8] = '{30, 18, 12, 8, 5, 3, 2, 1};
  localparam int EXP_LP  [8] = '{8, 18, 12, 8, 5, 3, 2, 1};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       slot_tick;
  logic [2:0] lvl_code;
  logic       ext_off;
  logic       br0, hf0, br1, hf1;

  int nchk  = 0;
  int nfail = 0;
  int bslot = 0;

  always #(CLK_NS / 2) clk = ~clk;

  intensity_pwm #(.PERIOD(PERIOD), .LOW_PWR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .lvl_code(lvl_code),
    .ext_off(ext_off), .bright_en(br0), .half_en(hf0));

  intensity_pwm #(.PERIOD(PERIOD), .LOW_PWR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .lvl_code(lvl_code),
    .ext_off(ext_off), .bright_en(br1), .half_en(hf1));

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s slot %0d: got %b expected %b", tag, bslot, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
    bslot = (bslot + 1) % PERIOD;
  endtask

  // Check every slot of one period, ending back at slot 0.
  task automatic run_period(input string tag, input int e0, input int e1);
    for (int s = 0; s < PERIOD; s++) begin
      logic b0, b1, odd;
      b0  = ext_off || (s < e0);
      b1  = ext_off || (s < e1);
      odd = (s % 2) == 1;
      chk({tag, " std bright"}, br0, b0);
      chk({tag, " std half R6"}, hf0, b0 && odd);
      chk({tag, " lp bright"}, br1, b1);
      chk({tag, " lp half R6"}, hf1, b1 && odd);
      tick();
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int prev0, prev1;
    rst_n = 1'b0; slot_tick = 1'b0; lvl_code = 3'd0; ext_off = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state, code 000 at slot 0
    chk("R1 std bright", br0, 1'b1);
    chk("R1 std half", hf0, 1'b0);
    chk("R1 lp bright", br1, 1'b1);
    chk("R1 lp half", hf1, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 std bright after release", br0, 1'b1);

    // Vector walk: each code shown one period early (R4), then measured (R2, R3)
    prev0 = EXP_STD[0];
    prev1 = EXP_LP[0];
    for (int i = 0; i < 8; i++) begin
      lvl_code = 3'(i);
      run_period("R4 old code", prev0, prev1);
      run_period("R2 R3 new code", EXP_STD[i], EXP_LP[i]);
      prev0 = EXP_STD[i];
      prev1 = EXP_LP[i];
    end

    // R5: override at the dimmest code
    ext_off = 1'b1;
    run_period("R5 override", 1, 1);
    ext_off = 1'b0;

    // R7: hold without ticks, with code 3 (8 on-slots)
    lvl_code = 3'd3;
    run_period("R4 old code", 1, 1);
    repeat (7) tick();
    chk("R7 bright at slot 7", br0, 1'b1);
    chk("R7 half at slot 7", hf0, 1'b1);
    repeat (6) @(negedge clk);
    chk("R7 bright held", br0, 1'b1);
    chk("R7 half held", hf0, 1'b1);
    tick();
    chk("R7 bright off at slot 8", br0, 1'b0);
    repeat (PERIOD - 8) tick();
    chk("R8 wrap back on", br0, 1'b1);
    chk("R8 wrap phase even", hf0, 1'b0);

    // R1: reset mid-period brings back code 000 and slot 0
    repeat (5) tick();
    chk("R1 off before reset", br0, 1'b1);
    repeat (4) tick();
    chk("R1 off before reset slot 9", br0, 1'b0);
    lvl_code = 3'd5;
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 std bright in reset", br0, 1'b1);
    chk("R1 lp half in reset", hf1, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bslot = 0;
    run_period("R1 default code", EXP_STD[0], EXP_LP[0]);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule